// File: doc/BRIEF.md
# Scannable Pipeline Register Chain

This block is a short synchronous datapath. Four 8-bit registers sit in a row, with a fixed combinational operation before each of them. The first register takes the data input as it is. The second adds a constant, the third applies an XOR mask and the fourth rotates left. Every register bit is a scan flip-flop, and all the bits are stitched into one serial path. A single test-select input switches every flip-flop at once between two modes:

- **Capture mode:** each flip-flop takes its functional value.
- **Shift mode:** each flip-flop takes the bit from its neighbour in the chain.

In shift mode the 32 register bits therefore form one long shift register. It runs from a serial input pin to a serial output pin.

A test sequence has three steps:

1. Shift a stimulus vector in over 32 edges.
2. Drop the test select for exactly one edge, so that every stage captures its response to the loaded values at the same time.
3. Shift the responses out. At the same time, the next vector can be shifted in.

The only pins this adds are the test select, the serial input and the serial output.

Top module: `scan_pipe_chain`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register bit is cleared on that edge, whatever the value of `test_en`. Afterwards `dout` reads 0, `scan_out` reads 0, and a full unload returns 32 zero bits.
- R2: With `test_en` low, the first register (chain bits 7:0) loads `din` on each clock edge.
- R3: With `test_en` low, the second register (chain bits 15:8) loads the first register's value plus 0x35, modulo 256.
- R4: With `test_en` low, the third register (chain bits 23:16) loads the second register's value XOR 0xA5.
- R5: With `test_en` low, the fourth register (chain bits 31:24) loads the third register's value rotated left by 3 bit positions. `dout` shows the fourth register, so a `din` value appears at `dout`, transformed, after four edges.
- R6: With `test_en` high, each edge shifts the chain by one position, as follows:
  - `scan_in` enters chain bit 0, which is bit 0 of the first register.
  - Chain bit i moves to bit i+1. Bit 7 of one register feeds bit 0 of the next.
  - `scan_out` always equals chain bit 31, which is bit 7 of the fourth register.
  - A bit shifted in reaches `scan_out` after 32 edges.
- R7: With `test_en` high, `din` has no effect. Shifting a 32-bit vector in and then straight back out returns that same vector, whatever `din` does during the shifts.
- R8: A single `test_en`-low edge between a shift-in and a shift-out updates all four registers at once, each from the values loaded into the previous stage. `dout` then shows the rotated third-register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low clear of all register bits |
| test_en | input | 1 | 1 = shift chain, 0 = functional capture |
| scan_in | input | 1 | Serial data entering chain bit 0 |
| din | input | 8 | Functional data into the first stage |
| dout | output | 8 | Contents of the last pipeline register |
| scan_out | output | 1 | Serial data leaving chain bit 31 |

## Verification
The hardest state to reach from the pins is one where each register holds a chosen value unrelated to its neighbours, because in functional mode the stage values are tied to one another by the pipeline arithmetic. The bench reaches that state only by shifting random 32-bit vectors in while it drives junk on `din`. It then applies one capture edge with a random `din` and shifts the whole chain back out. It compares each byte of the unloaded word with the stage arithmetic applied to the matching byte of the loaded word. A separate sweep pushes all 256 `din` values through the pipeline in functional mode. Reset is applied with the chain full of ones, in both modes.

// File: rtl/scan_pipe_pkg.sv
package scan_pipe_pkg;

    // Operation applied by the combinational stage in front of a register.
    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_ADD  = 2'd1,
        OP_XOR  = 2'd2,
        OP_ROTL = 2'd3
    } stage_op_e;

    // Stage order repeats pass, add, xor, rotate along the pipeline.
    function automatic stage_op_e op_for_stage(input int idx);
        case (idx % 4)
            0:       return OP_PASS;
            1:       return OP_ADD;
            2:       return OP_XOR;
            default: return OP_ROTL;
        endcase
    endfunction

    // State held by one scan cell.
    typedef struct packed {
        logic bit_val;
    } cell_state_t;

endpackage

// File: rtl/scan_cell.sv
module scan_cell
    import scan_pipe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic test_en,
    input  logic d,
    input  logic si,
    output logic q
);

    cell_state_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (!rst_n) begin
            cell_d.bit_val = 1'b0;
        end else if (test_en) begin
            cell_d.bit_val = si;
        end else begin
            cell_d.bit_val = d;
        end
    end

    always_ff @(posedge clk) begin
        cell_q <= cell_d;
    end

    // The stored bit doubles as the serial output: no extra storage per bit.
    assign q = cell_q.bit_val;

endmodule

// File: rtl/scan_reg.sv
module scan_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_en,
    input  logic [W-1:0] d,
    input  logic         si,
    output logic [W-1:0] q,
    output logic         so
);

    localparam int LINKS = W + 1;

    logic [LINKS-1:0] link;

    assign link[0] = si;

    generate
        for (genvar b = 0; b < W; b++) begin : g_cell
            scan_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .test_en (test_en),
                .d       (d[b]),
                .si      (link[b]),
                .q       (q[b])
            );
            assign link[b+1] = q[b];
        end
    endgenerate

    assign so = link[W];

    AST_SHIFT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |=> q == {$past(q[W-2:0]), $past(si)});  // R6

    AST_FUNC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> q == $past(d));  // R8

endmodule

// File: rtl/pipe_stage.sv
module pipe_stage
    import scan_pipe_pkg::*;
#(
    parameter int        W   = 8,
    parameter stage_op_e OP  = OP_PASS,
    parameter logic [W-1:0] K = '0,
    parameter int        ROT = 1
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);

    localparam int RS = ROT % W;

    logic [2*W-1:0] dbl;

    always_comb begin
        dbl = {a, a} << RS;
        case (OP)
            OP_ADD:  y = a + K;
            OP_XOR:  y = a ^ K;
            OP_ROTL: y = dbl[2*W-1:W];
            default: y = a;
        endcase
    end

endmodule

// File: rtl/scan_pipe_chain.sv
module scan_pipe_chain
    import scan_pipe_pkg::*;
#(
    parameter int         W       = 8,
    parameter int         NSTAGES = 4,
    parameter logic [W-1:0] ADD_K = 8'h35,
    parameter logic [W-1:0] XOR_K = 8'hA5,
    parameter int         ROT_N   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_en,
    input  logic         scan_in,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         scan_out
);

    localparam int LAST = NSTAGES - 1;

    logic [W-1:0] stage_src [NSTAGES];
    logic [W-1:0] stage_in  [NSTAGES];
    logic [W-1:0] stage_q   [NSTAGES];
    logic         link      [NSTAGES+1];

    assign link[0] = scan_in;

    generate
        for (genvar i = 0; i < NSTAGES; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign stage_src[i] = din;
            end else begin : g_body
                assign stage_src[i] = stage_q[i-1];
            end

            pipe_stage #(
                .W   (W),
                .OP  (op_for_stage(i)),
                .K   ((i % 4 == 1) ? ADD_K : XOR_K),
                .ROT (ROT_N)
            ) u_op (
                .a (stage_src[i]),
                .y (stage_in[i])
            );

            scan_reg #(
                .W (W)
            ) u_reg (
                .clk     (clk),
                .rst_n   (rst_n),
                .test_en (test_en),
                .d       (stage_in[i]),
                .si      (link[i]),
                .q       (stage_q[i]),
                .so      (link[i+1])
            );
        end
    endgenerate

    assign dout     = stage_q[LAST];
    assign scan_out = link[NSTAGES];

    AST_HEAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> stage_q[0] == $past(din));  // R2

    AST_SERIAL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |=> scan_out == $past(stage_q[LAST][W-2]));  // R6

    generate
        if (NSTAGES >= 4 && ROT_N > 0 && ROT_N < W) begin : g_stage_checks
            AST_ADD_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
                !test_en |=> stage_q[1] == W'($past(stage_q[0]) + ADD_K));  // R3

            AST_XOR_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
                !test_en |=> stage_q[2] == ($past(stage_q[1]) ^ XOR_K));  // R4

            AST_ROT_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
                !test_en |=> stage_q[3] ==
                    W'(($past(stage_q[2]) << ROT_N) | ($past(stage_q[2]) >> (W - ROT_N))));  // R5
        end
    endgenerate

endmodule

// File: tb/scan_pipe_chain_tb.sv
module scan_pipe_chain_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD         = 8;
    localparam int CHAIN      = 32;
    localparam logic [7:0] K_ADD = 8'h35;
    localparam logic [7:0] K_XOR = 8'hA5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_en = 1'b0;
    logic          scan_in = 1'b0;
    logic [WD-1:0] din = '0;
    logic [WD-1:0] dout;
    logic          scan_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    scan_pipe_chain u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_en  (test_en),
        .scan_in  (scan_in),
        .din      (din),
        .dout     (dout),
        .scan_out (scan_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] rot3(input logic [7:0] x);
        logic [15:0] w;
        w = {8'h00, x} * 16'd8;
        return w[7:0] | w[15:8];
    endfunction

    function automatic logic [7:0] pipe_fn(input logic [7:0] x);
        logic [7:0] s;
        s = x + K_ADD;
        s = s ^ K_XOR;
        return rot3(s);
    endfunction

    task automatic next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // Vector bit 31 goes in first so that it ends up in chain bit 31.
    task automatic shift_load(input logic [31:0] v);
        test_en = 1'b1;
        for (int k = CHAIN - 1; k >= 0; k--) begin
            scan_in = v[k];
            next_rand();
            din = rng[7:0];
            tick();
        end
    endtask

    task automatic shift_unload(output logic [31:0] got);
        test_en = 1'b1;
        for (int k = 0; k < CHAIN; k++) begin
            got[CHAIN-1-k] = scan_out;
            scan_in = 1'b0;
            next_rand();
            din = rng[7:0];
            tick();
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        logic [31:0] vec;
        logic [7:0]  dcap;
        logic [7:0]  hist [0:258];

        // Reset state (R1)
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        chk("R1 dout after reset", {24'h0, dout}, 32'h0);
        chk("R1 scan_out after reset", {31'h0, scan_out}, 32'h0);
        shift_unload(got);
        chk("R1 chain after reset", got, 32'h0);

        // Functional sweep of every din value (R5)
        test_en = 1'b0;
        for (int t = 0; t < 259; t++) begin
            hist[t] = (t < 256) ? t[7:0] : 8'h00;
            din = hist[t];
            tick();
            if (t >= 3)
                chk("R5 dout after four edges", {24'h0, dout}, {24'h0, pipe_fn(hist[t-3])});
        end

        // Shift in and straight back out, din toggling (R6, R7)
        for (int n = 0; n < 20; n++) begin
            next_rand();
            vec = rng;
            shift_load(vec);
            chk("R6 scan_out shows chain bit 31", {31'h0, scan_out}, {31'h0, vec[31]});
            shift_unload(got);
            chk("R6 R7 round trip", got, vec);
        end

        // Load, one capture edge, unload (R2, R3, R4, R5, R8)
        for (int n = 0; n < 40; n++) begin
            next_rand();
            vec = rng;
            next_rand();
            dcap = rng[15:8];
            shift_load(vec);
            test_en = 1'b0;
            din = dcap;
            tick();
            chk("R8 dout after capture", {24'h0, dout}, {24'h0, rot3(vec[23:16])});
            shift_unload(got);
            chk("R2 first register capture", {24'h0, got[7:0]}, {24'h0, dcap});
            chk("R3 add stage capture", {24'h0, got[15:8]}, {24'h0, 8'(vec[7:0] + K_ADD)});
            chk("R4 xor stage capture", {24'h0, got[23:16]}, {24'h0, vec[15:8] ^ K_XOR});
            chk("R5 rotate stage capture", {24'h0, got[31:24]}, {24'h0, rot3(vec[23:16])});
        end

        // Reset with test mode high, then low (R1)
        for (int m = 0; m < 2; m++) begin
            shift_load(32'hFFFF_FFFF);
            test_en = (m == 0);
            rst_n = 1'b0;
            tick();
            rst_n = 1'b1;
            chk("R1 dout cleared by reset", {24'h0, dout}, 32'h0);
            chk("R1 scan_out cleared by reset", {31'h0, scan_out}, 32'h0);
            shift_unload(got);
            chk("R1 chain cleared by reset", got, 32'h0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule